// File: doc/BRIEF.md
# UART Receive/Transmit Status Flag Controller

This block keeps the read-only status byte of a UART. The receive engine reports each finished word together with its noise, framing and parity results, plus the start-bit and stop-bit milestones. The transmit engine reports whether its holding register is empty and whether the shifter is busy with a character or a break. The bus side reports three single-cycle strobes: a status read, a data read and a data write. From these the block builds the status byte, a receive interrupt request and an inhibit signal that tells the receive path to stop loading words.

Error and idle flags are never cleared by one access. A status read first records which flags were set at that moment. Only those recorded flags are cleared by the next data register access. The block tracks how many received words are buffered, `RX_DEPTH` entries (default 2), so the receive-ready flag can stay set across a data read. All pins are plain control and status strobes or levels. There is no streaming payload, so there is no valid/ready handshake.

Top module: `uart_status_ctrl`

## Requirements
- R1: Status byte layout: bit 7 parity error, bit 6 noise, bit 5 framing error, bit 4 overrun, bit 3 receiver idle, bit 2 receive data available, bit 1 transmitter idle, bit 0 always 0. After reset all flags are 0 except receiver idle and transmitter idle. With holding-empty 1 and shifter idle, the byte reads 0x0A.
- R2: A received word that is loaded into the buffer sets the receive-available flag and its noise, framing and parity flags at the same clock edge. These are visible in the cycle after the `rx_word_done` strobe.
- R3: A word that arrives while the buffer holds `RX_DEPTH` words is not loaded. It sets the overrun flag and sets neither the noise flag nor the interrupt request.
- R4: Noise, framing, parity and overrun flags clear only on a data read or data write that follows a status read taken while the flag was set. A data access without that earlier status read leaves them set.
- R5: While the overrun flag is set, `rx_inhibit` is 1 and further received words change nothing.
- R6: Receiver idle goes to 0 in the cycle after a start-bit strobe and back to 1 in the cycle after a stop-complete strobe.
- R7: A data read that follows a status read taken while receive-available was set removes one buffered word. Receive-available clears only when no word remains.
- R8: `rx_irq` pulses for one cycle, at the same edge as the load, for each loaded word while `rx_int_en` is 1. It stays 0 while `rx_int_en` is 0.
- R9: Transmitter idle is 0 whenever holding-empty is 0 or the shifter is busy.
- R10: Transmitter idle clears on a data write that follows a status read taken while it was set. It stays clear until the idle condition is left and entered again. A data write without that earlier status read leaves it set.
- R11: A flag that sets after the status read survives the following data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_word_done | input | 1 | Receive engine finished a word (1-cycle strobe) |
| rx_noise | input | 1 | Noise seen on that word |
| rx_frame_err | input | 1 | Bad stop bit on that word |
| rx_parity_err | input | 1 | Parity mismatch on that word |
| rx_start_det | input | 1 | Start bit detected (strobe) |
| rx_stop_done | input | 1 | Stop bit completed (strobe) |
| tx_hold_empty | input | 1 | Transmit holding register empty (level) |
| tx_shift_busy | input | 1 | Shifter sending a character or break (level) |
| rx_int_en | input | 1 | Receive interrupt enable |
| bus_stat_rd | input | 1 | Status register read strobe |
| bus_data_rd | input | 1 | Data register read strobe |
| bus_data_wr | input | 1 | Data register write strobe |
| status_byte | output | 8 | Status flags, layout per R1 |
| rx_irq | output | 1 | Receive interrupt request pulse |
| rx_inhibit | output | 1 | Blocks loads while overrun is set |

## Verification
The hardest case to reach is a flag that sets between the status read and the data access. The stimulus has to place an error-carrying word exactly between the two bus strobes, while an earlier word keeps the buffer non-empty. The bench does this on purpose and expects the new error and the receive-available flag to survive the access. The overrun path needs the buffer filled to its depth before a noisy word arrives. The bench fills it with clean words first.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int ST_W  = 8;
  localparam int B_PE  = 7;
  localparam int B_NF  = 6;
  localparam int B_FE  = 5;
  localparam int B_OV  = 4;
  localparam int B_RI  = 3;
  localparam int B_RX  = 2;
  localparam int B_TI  = 1;
  localparam int N_ERR = 3;  // index 0 noise, 1 framing, 2 parity

  function automatic int err_bit(input int idx);
    case (idx)
      0:       return B_NF;
      1:       return B_FE;
      default: return B_PE;
    endcase
  endfunction
endpackage

// File: rtl/uart_seen_latch.sv
module uart_seen_latch
  import uart_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            data_rd,
  input  logic            data_wr,
  input  logic [ST_W-1:0] flags,
  output logic [ST_W-1:0] seen,
  output logic            access
);
  assign access = data_rd | data_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen <= '0;
    else if (stat_rd) seen <= flags;
    else if (access)  seen <= '0;
  end

  // R11: a data access consumes the record taken by the status read
  a_r11_seen_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !stat_rd) |=> (seen == '0));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_stat_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_done,
  input  logic [N_ERR-1:0] err_in,
  input  logic             start_det,
  input  logic             stop_done,
  input  logic             int_en,
  input  logic             data_rd,
  input  logic             access,
  input  logic [N_ERR-1:0] seen_err,
  input  logic             seen_ovr,
  input  logic             seen_rx,
  output logic [N_ERR-1:0] err_q,
  output logic             ovr_q,
  output logic             ridle_q,
  output logic             rxif,
  output logic             irq_q
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RX_DEPTH);

  logic [CNT_W-1:0] count_q;
  logic load, overflow, pop;

  assign load     = word_done && !ovr_q && (count_q != FULL);
  assign overflow = word_done && !ovr_q && (count_q == FULL);
  assign pop      = data_rd && seen_rx && (count_q != '0);
  assign rxif     = (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_q + CNT_W'(load) - CNT_W'(pop);
  end

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        err_q[i] <= 1'b0;
      else if (load && err_in[i])        err_q[i] <= 1'b1;
      else if (access && seen_err[i])    err_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovr_q <= 1'b0;
    else if (overflow)              ovr_q <= 1'b1;
    else if (access && seen_ovr)    ovr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ridle_q <= 1'b1;
    else if (start_det) ridle_q <= 1'b0;
    else if (stop_done) ridle_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= load && int_en;
  end

  // R3: an overflowing word never raises the noise flag
  a_r3_no_noise_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !ovr_q && count_q == FULL && !err_q[0]) |=> !err_q[0]);
  // R5: overrun freezes the buffer against new words
  a_r5_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && word_done && !pop) |=> $stable(count_q));
  // R7: receive-available only drops after an armed data read
  a_r7_rxif_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxif) |-> $past(data_rd && seen_rx));
  // R4: noise flag only drops through the read-then-access sequence
  a_r4_noise_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q[0]) |-> $past(access && seen_err[0]));
  // R6: start strobe drops receiver idle
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !ridle_q);
  // R8: interrupt only when enabled at the load
  a_r8_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(int_en && word_done));
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_empty,
  input  logic shift_busy,
  input  logic data_wr,
  input  logic seen_ti,
  output logic tidle
);
  logic cond, prev_q, arm_q, rise;

  assign cond  = hold_empty && !shift_busy;
  assign rise  = cond && !prev_q;
  assign tidle = arm_q && cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   arm_q <= 1'b1;
    else if (rise)                arm_q <= 1'b1;
    else if (data_wr && seen_ti)  arm_q <= 1'b0;
  end

  // R10: an armed write clears transmitter idle unless idle is re-entered
  a_r10_tidle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(data_wr && seen_ti) && !$past(rise)) |-> !tidle);
endmodule

// File: rtl/uart_status_ctrl.sv
module uart_status_ctrl
  import uart_stat_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_word_done,
  input  logic       rx_noise,
  input  logic       rx_frame_err,
  input  logic       rx_parity_err,
  input  logic       rx_start_det,
  input  logic       rx_stop_done,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_busy,
  input  logic       rx_int_en,
  input  logic       bus_stat_rd,
  input  logic       bus_data_rd,
  input  logic       bus_data_wr,
  output logic [7:0] status_byte,
  output logic       rx_irq,
  output logic       rx_inhibit
);
  logic [ST_W-1:0]  seen;
  logic             access;
  logic [N_ERR-1:0] err_q, seen_err;
  logic             ovr_q, ridle_q, rxif, tidle;

  for (genvar i = 0; i < N_ERR; i++) begin : g_map
    assign seen_err[i]            = seen[err_bit(i)];
    assign status_byte[err_bit(i)] = err_q[i];
  end
  assign status_byte[B_OV] = ovr_q;
  assign status_byte[B_RI] = ridle_q;
  assign status_byte[B_RX] = rxif;
  assign status_byte[B_TI] = tidle;
  assign status_byte[0]    = 1'b0;
  assign rx_inhibit        = ovr_q;

  uart_seen_latch u_seen (
    .clk(clk), .rst_n(rst_n), .stat_rd(bus_stat_rd), .data_rd(bus_data_rd),
    .data_wr(bus_data_wr), .flags(status_byte), .seen(seen), .access(access)
  );

  uart_rx_flags #(.RX_DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .word_done(rx_word_done),
    .err_in({rx_parity_err, rx_frame_err, rx_noise}),
    .start_det(rx_start_det), .stop_done(rx_stop_done), .int_en(rx_int_en),
    .data_rd(bus_data_rd), .access(access), .seen_err(seen_err),
    .seen_ovr(seen[B_OV]), .seen_rx(seen[B_RX]), .err_q(err_q), .ovr_q(ovr_q),
    .ridle_q(ridle_q), .rxif(rxif), .irq_q(rx_irq)
  );

  uart_tx_flags u_tx (
    .clk(clk), .rst_n(rst_n), .hold_empty(tx_hold_empty),
    .shift_busy(tx_shift_busy), .data_wr(bus_data_wr), .seen_ti(seen[B_TI]),
    .tidle(tidle)
  );

  // R5: inhibit tracks overrun state
  a_r5_inhibit_out: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !$past(rx_inhibit));
endmodule

// File: tb/sim_uart_status_ctrl.sv
module sim_uart_status_ctrl;
  logic clk = 0, rst_n = 0;
  logic rx_word_done = 0, rx_noise = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic rx_start_det = 0, rx_stop_done = 0, tx_hold_empty = 1, tx_shift_busy = 0;
  logic rx_int_en = 0, bus_stat_rd = 0, bus_data_rd = 0, bus_data_wr = 0;
  logic [7:0] status_byte;
  logic rx_irq, rx_inhibit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_status_ctrl u0 (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic word(input logic n, input logic f, input logic p);
    rx_word_done = 1; rx_noise = n; rx_frame_err = f; rx_parity_err = p;
    tick();
    rx_word_done = 0; rx_noise = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask
  task automatic srd(); bus_stat_rd = 1; tick(); bus_stat_rd = 0; endtask
  task automatic drd(); bus_data_rd = 1; tick(); bus_data_rd = 0; endtask
  task automatic dwr(); bus_data_wr = 1; tick(); bus_data_wr = 0; endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R1 reset", status_byte, 8'h0A);

    // R2/R8 sweep of every error combination, interrupt enable alternating
    for (int e = 0; e < 8; e++) begin
      rx_int_en = e[0] ^ e[2];
      word(e[0], e[1], e[2]);
      chk("R2 load flags", status_byte,
          8'h0E | (8'(e[0]) << 6) | (8'(e[1]) << 5) | (8'(e[2]) << 7));
      chk("R8 irq", {7'd0, rx_irq}, {7'd0, e[0] ^ e[2]});
      tick();
      chk("R8 irq one cycle", {7'd0, rx_irq}, 8'h00);
      srd(); drd();
      chk("R4 R7 sequence clear", status_byte, 8'h0A);
    end
    rx_int_en = 1;

    // R4: access without status read leaves flags
    word(1, 0, 0);
    drd();
    chk("R4 read alone", status_byte, 8'h4E);
    srd();
    chk("R4 status read alone", status_byte, 8'h4E);
    drd();
    chk("R4 completed", status_byte, 8'h0A);

    // R4/R10: write also clears errors; receive-available needs a read
    word(0, 1, 0);
    srd(); dwr();
    chk("R4 R10 write clears frame and tidle", status_byte, 8'h0C);
    tx_hold_empty = 0; tick(); tx_hold_empty = 1; tick();
    chk("R10 idle re-entered", status_byte, 8'h0E);
    srd(); drd();
    chk("R7 clear", status_byte, 8'h0A);

    // R11/R7: flag set between status read and access survives
    word(0, 0, 0);
    srd();
    word(0, 1, 0);
    chk("R2 second word", status_byte, 8'h2E);
    drd();
    chk("R11 late frame error survives, R7 one left", status_byte, 8'h2E);
    srd(); drd();
    chk("R7 buffer empty", status_byte, 8'h0A);

    // R3/R5: overrun
    word(0, 0, 0); word(0, 0, 0);
    word(1, 0, 0);
    chk("R3 overrun no noise", status_byte, 8'h1E);
    chk("R3 no irq", {7'd0, rx_irq}, 8'h00);
    chk("R5 inhibit", {7'd0, rx_inhibit}, 8'h01);
    word(0, 1, 1);
    chk("R5 ignored word", status_byte, 8'h1E);
    chk("R5 no irq", {7'd0, rx_irq}, 8'h00);
    srd(); drd();
    chk("R4 overrun cleared R7 one left", status_byte, 8'h0E);
    chk("R5 inhibit released", {7'd0, rx_inhibit}, 8'h00);
    srd(); drd();
    chk("R7 drained", status_byte, 8'h0A);

    // R6: receiver idle
    rx_start_det = 1; tick(); rx_start_det = 0;
    chk("R6 busy", status_byte, 8'h02);
    tick();
    chk("R6 still busy", status_byte, 8'h02);
    rx_stop_done = 1; tick(); rx_stop_done = 0;
    chk("R6 idle", status_byte, 8'h0A);

    // R9/R10: transmitter idle
    tx_hold_empty = 0; #1;
    chk("R9 queued", status_byte, 8'h08);
    tick();
    tx_hold_empty = 1; tx_shift_busy = 1; #1;
    chk("R9 shifting", status_byte, 8'h08);
    tick();
    tx_shift_busy = 0; tick();
    chk("R9 idle again", status_byte, 8'h0A);
    dwr();
    chk("R10 write alone", status_byte, 8'h0A);
    srd(); dwr();
    chk("R10 cleared", status_byte, 8'h08);
    tick(); tick();
    chk("R10 stays cleared", status_byte, 8'h08);
    tx_shift_busy = 1; tick(); tx_shift_busy = 0; tick();
    chk("R10 re-entered idle", status_byte, 8'h0A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule